// File: doc/BRIEF.md
# Calibrated Oscillator Prescaler

This block turns a 32,768 Hz oscillator clock into a one-second timekeeping tick, a minute strobe and a free-running 512 Hz frequency-test square wave. A fast stage divides the oscillator by 256. A second stage counts half-periods of that fast stage to build each second. Digital rate correction works at the granularity of the fast stage, so a correction never disturbs the test output.

Correction follows a 64-minute cycle. A 5-bit magnitude N and a direction bit select the adjustment. In each of the first 2N minutes of the cycle, the first second of the minute is adjusted. Speeding up removes one full fast-stage period (256 oscillator cycles) from that second. Slowing down adds half a fast-stage period (128 cycles). Minutes 62 and 63 are never adjusted. A halt input freezes timekeeping and clears the sub-second divider. The position within the minute and within the 64-minute cycle is kept, so the interrupted second restarts in full when the halt is removed.

All pins are plain control and status signals. There is no streaming data, so there is no valid/ready handshake. The block runs directly on the oscillator clock.

Top module: `calib_prescaler`

## Requirements
- R1: While reset is asserted, sec_tick, min_tick and ftest_out are all low.
- R2: With cal_mag = 0 every second lasts SEC_DIV * 2^LOW_W clock cycles (32,768 by default), measured between consecutive sec_tick pulses.
- R3: sec_tick is a single-cycle pulse. min_tick pulses together with the sec_tick that ends the last second of each minute (every SEC_PER_MIN ticks).
- R4: With cal_speedup = 1, the first second of minute m of the 64-minute cycle is 2^LOW_W cycles (256) shorter when m < 2 * cal_mag.
- R5: With cal_speedup = 0, that same second is 2^(LOW_W-1) cycles (128) longer when m < 2 * cal_mag.
- R6: The minute position is a 6-bit counter that wraps from 63 to 0. Minutes at or beyond 2 * cal_mag, and minutes 62 and 63, are never adjusted, and the pattern repeats in every cycle.
- R7: ftest_out equals bit FT_BIT of the count of clock cycles since reset or halt release. It toggles every 2^FT_BIT cycles (a 512 Hz square wave by default), whatever the calibration setting.
- R8: While halt is high, no sec_tick occurs and ftest_out is low. After halt falls, the next sec_tick comes exactly one full second length (adjusted if due) later, and the minute position is preserved.
- R9: Over one full 64-minute cycle, the total length differs from nominal by exactly -2N * 2^LOW_W cycles when speeding up, and by +2N * 2^(LOW_W-1) cycles when slowing down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock (nominally 32,768 Hz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt | input | 1 | Stops timekeeping and clears the sub-second divider |
| cal_mag | input | MAG_W | Calibration magnitude N (0..31) |
| cal_speedup | input | 1 | 1: shorten adjusted seconds; 0: lengthen them |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse with the last sec_tick of each minute |
| ftest_out | output | 1 | Calibration-independent frequency-test square wave |

## Verification
The bench shrinks the divider so that whole 64-minute cycles fit in a run. It sweeps magnitudes from 0 to 31 in both directions and predicts the length of every second from its minute and second index. One failure mode it targets is a design that adjusts the wrong second or the wrong number of minutes. Such a design would get individual intervals and the per-cycle total wrong. Another is a design that fails to wrap at minute 64, or that adjusts minutes 62 and 63 at magnitude 31; this would show up as a second of the wrong length right after the cycle boundary. A test output derived from the corrected chain would drift against the arithmetic cycle count during adjusted seconds. A halt that does not clear the sub-second divider, or that loses the minute position, would make the first tick after release come early or fall on the wrong schedule.

// File: rtl/calib_prescaler_pkg.sv
package calib_prescaler_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_mode_e;
endpackage

// File: rtl/cal_fast_div.sv
module cal_fast_div #(
  parameter int LOW_W  = 8,
  parameter int FT_BIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic half_pulse,
  output logic ftest
);
  logic [LOW_W-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_cnt <= '0;
    else if (halt) lo_cnt <= '0;
    else           lo_cnt <= lo_cnt + 1'b1;
  end

  assign half_pulse = !halt && (&lo_cnt[LOW_W-2:0]);
  assign ftest      = lo_cnt[FT_BIT];

  // R8
  halt_clears_ft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !ftest);
endmodule

// File: rtl/cal_second_div.sv
module cal_second_div
  import calib_prescaler_pkg::*;
#(
  parameter int SEC_DIV = 128
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt,
  input  logic      half_pulse,
  input  adj_mode_e adj_mode,
  output logic      sec_tick
);
  localparam int HALVES = 2 * SEC_DIV;
  localparam int HI_W   = $clog2(HALVES + 1);
  localparam logic [HI_W-1:0] TERM_NOM   = HI_W'(HALVES - 1);
  localparam logic [HI_W-1:0] TERM_SHORT = HI_W'(HALVES - 3);
  localparam logic [HI_W-1:0] TERM_LONG  = HI_W'(HALVES);

  logic [HI_W-1:0] hi_cnt;
  logic [HI_W-1:0] term;
  logic            at_term;

  always_comb begin
    unique case (adj_mode)
      ADJ_SHORT: term = TERM_SHORT;
      ADJ_LONG:  term = TERM_LONG;
      default:   term = TERM_NOM;
    endcase
  end

  assign at_term = half_pulse && (hi_cnt >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      sec_tick <= 1'b0;
    end else if (halt) begin
      hi_cnt   <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= at_term;
      if (at_term)         hi_cnt <= '0;
      else if (half_pulse) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= TERM_LONG);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  // R8
  halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !sec_tick);
endmodule

// File: rtl/cal_cycle_track.sv
module cal_cycle_track
  import calib_prescaler_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_W       = 6,
  parameter int MAG_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_speedup,
  output adj_mode_e        adj_mode,
  output logic             min_tick
);
  localparam int SEC_W     = $clog2(SEC_PER_MIN);
  localparam int ELIG_MIN  = (1 << MIN_W) - 2;
  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] LAST_MIN = '1;

  logic [SEC_W-1:0] sec_idx;
  logic [MIN_W-1:0] min_idx;
  logic             due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_idx <= '0;
      min_idx <= '0;
    end else if (sec_tick) begin
      if (sec_idx == LAST_SEC) begin
        sec_idx <= '0;
        min_idx <= min_idx + 1'b1;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  assign due = (sec_idx == '0) &&
               (int'(min_idx) < 2 * int'(cal_mag)) &&
               (int'(min_idx) < ELIG_MIN);

  always_comb begin
    if (!due)             adj_mode = ADJ_NONE;
    else if (cal_speedup) adj_mode = ADJ_SHORT;
    else                  adj_mode = ADJ_LONG;
  end

  assign min_tick = sec_tick && (sec_idx == LAST_SEC);

  // R6
  cycle_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && min_idx == LAST_MIN) |=> (min_idx == '0));
endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
  import calib_prescaler_pkg::*;
#(
  parameter int LOW_W       = 8,
  parameter int SEC_DIV     = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_W       = 6,
  parameter int MAG_W       = 5,
  parameter int FT_BIT      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_speedup,
  output logic             sec_tick,
  output logic             min_tick,
  output logic             ftest_out
);
  logic      half_pulse;
  adj_mode_e adj_mode;

  cal_fast_div #(.LOW_W(LOW_W), .FT_BIT(FT_BIT)) u_fast (
    .clk(clk), .rst_n(rst_n), .halt(halt),
    .half_pulse(half_pulse), .ftest(ftest_out)
  );

  cal_second_div #(.SEC_DIV(SEC_DIV)) u_sec (
    .clk(clk), .rst_n(rst_n), .halt(halt), .half_pulse(half_pulse),
    .adj_mode(adj_mode), .sec_tick(sec_tick)
  );

  cal_cycle_track #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_W(MIN_W), .MAG_W(MAG_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cal_mag(cal_mag),
    .cal_speedup(cal_speedup), .adj_mode(adj_mode), .min_tick(min_tick)
  );

  // R3
  min_with_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min_tick |-> sec_tick);
endmodule

// File: tb/calib_prescaler_test.sv
module calib_prescaler_test;
  localparam int LOW_W = 3, SEC_DIV = 4, SPM = 3, MIN_W = 6, MAG_W = 5, FT_BIT = 1;
  localparam int NOM = SEC_DIV * (1 << LOW_W);
  localparam int SHORT_BY = 1 << LOW_W;
  localparam int LONG_BY = 1 << (LOW_W - 1);
  localparam int CYC_MIN = 1 << MIN_W;

  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0, cal_speedup = 1'b0;
  logic [MAG_W-1:0] cal_mag = '0;
  logic sec_tick, min_tick, ftest_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  calib_prescaler #(.LOW_W(LOW_W), .SEC_DIV(SEC_DIV), .SEC_PER_MIN(SPM),
    .MIN_W(MIN_W), .MAG_W(MAG_W), .FT_BIT(FT_BIT)) uut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cal_mag(cal_mag),
    .cal_speedup(cal_speedup), .sec_tick(sec_tick), .min_tick(min_tick),
    .ftest_out(ftest_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int sec_len(int t, int mag, bit spd);
    int s = t % SPM;
    int m = (t / SPM) % CYC_MIN;
    if (s == 0 && m < 2 * mag && m < CYC_MIN - 2) return spd ? NOM - SHORT_BY : NOM + LONG_BY;
    return NOM;
  endfunction

  task automatic run_case(input int mag, input bit spd, input bit halt_mid);
    int n, total, ticks, sum, tlimit;
    bit ok_ft, ok_ticks;
    @(negedge clk);
    rst_n = 1'b0; halt = 1'b1;
    cal_mag = MAG_W'(mag); cal_speedup = spd;
    repeat (3) @(negedge clk);
    check(!sec_tick && !min_tick && !ftest_out, "R1 reset outputs", {sec_tick, min_tick, ftest_out}, 0);
    rst_n = 1'b1;
    ok_ticks = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sec_tick || ftest_out) ok_ticks = 0;
    end
    check(ok_ticks, "R8 halted from start", 0, 1);
    halt = 1'b0;
    n = 0; total = 0; ticks = 0; sum = 0; ok_ft = 1;
    tlimit = (CYC_MIN + 2) * SPM;
    while (ticks < tlimit) begin
      @(negedge clk);
      n++; total++;
      if (ftest_out !== 1'((total >> FT_BIT) & 1)) ok_ft = 0;
      if (sec_tick) begin
        int exp_len = sec_len(ticks, mag, spd);
        string rq = (exp_len == NOM) ? "R2/R6 nominal second" : (spd ? "R4 short second" : "R5 long second");
        check(n == exp_len, rq, n, exp_len);
        check(min_tick == ((ticks % SPM) == SPM - 1), "R3 minute strobe", min_tick, (ticks % SPM) == SPM - 1);
        if (ticks < CYC_MIN * SPM) sum += n;
        ticks++; n = 0;
        if (halt_mid && ticks == 100) begin
          repeat (5) begin @(negedge clk); n++; total++; end
          halt = 1'b1;
          ok_ticks = 1;
          for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sec_tick || ftest_out) ok_ticks = 0;
          end
          check(ok_ticks, "R8 mid-run halt silent", 0, 1);
          halt = 1'b0; n = 0; total = 0;
        end
      end else begin
        if (min_tick) check(0, "R3 min_tick without sec_tick", 1, 0);
      end
    end
    check(ok_ft, "R7 test output unaffected by calibration", 0, 1);
    if (!halt_mid) begin
      int exp_sum = CYC_MIN * SPM * NOM + (spd ? -2 * mag * SHORT_BY : 2 * mag * LONG_BY);
      check(sum == exp_sum, "R9 cycle total", sum, exp_sum);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int mags[7] = '{0, 1, 2, 7, 15, 30, 31};
    foreach (mags[k]) begin
      run_case(mags[k], 1'b1, 1'b0);
      run_case(mags[k], 1'b0, 1'b0);
    end
    run_case(3, 1'b1, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule